// File: doc/BRIEF.md
# Slew-Limited CPU Frequency Selector

This block picks the operating frequency of a processor clock from a small table of eight entries and walks the output towards it gradually. Three select inputs name the wanted entry. After they pass through a synchronizer and stay unchanged for a set number of time ticks, that entry becomes the target. On each later tick the current frequency code moves towards the target by a bounded step. The clock therefore ramps from one frequency to the next and never jumps. The current code drives the multiplier of an external PLL. A two-bit post-divider choice and a settled flag go with it.

Software-side logic loads the table entries. A loaded code is clamped into the limit window in force at load time. The step size applied per tick is forced into the range 1 to `STEP_MAX`. When a mode input is set, the top select bit stops choosing frequencies and becomes an active-low suspend request. Only four entries can then be chosen. Frequencies are integer codes, and one code unit per tick stands for a slope in MHz per millisecond when ticks come once a millisecond.

Top module: `cpu_slew_sel`

## Requirements
- R1: After reset, freqCode equals RST_CODE (8), postDiv is 2'b00, settled is 1 and suspendOut is 0. Every table entry holds code RST_CODE and divider 2'b00.
- R2: A table write stores the code clamped to the window [minCode, maxCode] that is in force during the write cycle. A code below the window is stored as minCode, and a code above it is stored as maxCode.
- R3: The divider field encodes 2'b00 as divide by 1, 2'b01 as divide by 2 and 2'b10 as divide by 4. A written 2'b11 is stored as 2'b10. postDiv shows the field of the active entry and changes when that entry is latched.
- R4: A new select value is synchronized and then latched as the active entry on the DEB_TICKS-th tick (3 by default) during which it has stayed unchanged. If the select changes before that tick, the count starts again.
- R5: On each tick, freqCode moves towards the target by the effective step, or by the remaining gap if that gap is smaller, so it never overshoots. Without a tick, freqCode holds its value.
- R6: The effective step is stepSize. A stepSize of 0 acts as 1, and a stepSize above STEP_MAX (20) acts as STEP_MAX.
- R7: A retarget made during a ramp continues from the current freqCode and never restarts from an earlier endpoint.
- R8: settled is 1 exactly when freqCode equals the code of the active entry.
- R9: With suspendMode set, selIn[2] takes no part in choosing the entry, and the index is {0, selIn[1:0]}. suspendOut equals the inverted synchronized selIn[2], so a low bit means suspend. With suspendMode clear, suspendOut is 0.
- R10: On the tick that latches a new entry, the step still moves towards the previous target. The new target takes effect from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 3 | Asynchronous frequency select |
| suspendMode | input | 1 | Makes selIn[2] an active-low suspend request |
| tickIn | input | 1 | Time-base strobe, one cycle wide |
| stepSize | input | 5 | Requested code step per tick |
| minCode | input | 8 | Lower limit for table loads |
| maxCode | input | 8 | Upper limit for table loads |
| tableWrEn | input | 1 | Table write strobe |
| tableWrIdx | input | 3 | Table entry to write |
| tableWrCode | input | 8 | Frequency code to write |
| tableWrDiv | input | 2 | Post-divider field to write |
| freqCode | output | 8 | Current frequency code for the PLL multiplier |
| postDiv | output | 2 | Post-divider choice of the active entry |
| settled | output | 1 | Current code has reached the target |
| suspendOut | output | 1 | Suspend request decoded from the select |

## Verification
The debounce latch and the ramp step always fall in the same cycle, because a new entry can only be latched on a tick, and every tick also moves the ramp. The bench provokes this on every retarget, including one made halfway down a ramp. The bench's own model checks that the latching tick still steps towards the old target and that the next tick turns towards the new one. A select change made partway through the debounce count confirms that the count restarts and that no step is lost in the meantime.

// File: rtl/cpuslew_pkg.sv
package cpuslew_pkg;
  localparam int SEL_W       = 3;
  localparam int NUM_ENTRIES = 1 << SEL_W;
  localparam int DIV_W       = 2;

  typedef enum logic [DIV_W-1:0] {
    DIV_BY1 = 2'b00,
    DIV_BY2 = 2'b01,
    DIV_BY4 = 2'b10
  } postDiv_e;

  typedef struct packed {
    logic             latchTarget;
    logic             rampTick;
    logic [SEL_W-1:0] newIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/cpuslew_ctrl.sv
module cpuslew_ctrl
  import cpuslew_pkg::*;
#(
  parameter int DEB_TICKS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selIn,
  input  logic             suspendMode,
  input  logic             tickIn,
  output ctlStrobe_t       strb,
  output logic             suspendOut
);
  localparam int CNT_W = $clog2(DEB_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DEB_TICKS);
  localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(DEB_TICKS - 1);

  logic [SEL_W-1:0] syncA, syncB;
  logic [SEL_W-1:0] candIdx;
  logic [CNT_W-1:0] stableCnt;
  logic [SEL_W-1:0] liveIdx;

  // two-flop synchronizer on the select pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= selIn;
      syncB <= syncA;
    end
  end

  // in suspend mode the top bit is not part of the index
  always_comb begin
    liveIdx = syncB;
    if (suspendMode) liveIdx[SEL_W-1] = 1'b0;
  end

  // debounce: candidate must hold for DEB_TICKS ticks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      candIdx   <= '0;
      stableCnt <= CNT_TOP;
    end else if (liveIdx != candIdx) begin
      candIdx   <= liveIdx;
      stableCnt <= '0;
    end else if (tickIn && (stableCnt != CNT_TOP)) begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  always_comb begin
    strb.rampTick    = tickIn;
    strb.latchTarget = tickIn && (liveIdx == candIdx) && (stableCnt == CNT_ARM);
    strb.newIdx      = candIdx;
  end

  assign suspendOut = suspendMode & ~syncB[SEL_W-1];

  // R4: a latch never follows a change of the decoded select in the previous cycle
  assert_latch_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchTarget |-> (liveIdx == $past(liveIdx)));

  // R9: no suspend request outside suspend mode
  assert_suspend_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    suspendOut |-> suspendMode);
endmodule

// File: rtl/cpuslew_datapath.sv
module cpuslew_datapath
  import cpuslew_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int STEP_W   = 5,
  parameter int STEP_MAX = 20,
  parameter int RST_CODE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              tableWrEn,
  input  logic [SEL_W-1:0]  tableWrIdx,
  input  logic [CODE_W-1:0] tableWrCode,
  input  logic [DIV_W-1:0]  tableWrDiv,
  input  logic [STEP_W-1:0] stepSize,
  input  logic [CODE_W-1:0] minCode,
  input  logic [CODE_W-1:0] maxCode,
  output logic [CODE_W-1:0] freqCode,
  output logic [DIV_W-1:0]  postDiv,
  output logic              settled
);
  localparam logic [CODE_W-1:0] STEP_CAP  = CODE_W'(STEP_MAX);
  localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(RST_CODE);

  logic [CODE_W-1:0] entryCode [NUM_ENTRIES];
  logic [DIV_W-1:0]  entryDiv  [NUM_ENTRIES];
  logic [CODE_W-1:0] wrClamped;
  logic [DIV_W-1:0]  wrDivFix;
  logic [SEL_W-1:0]  activeIdx;
  logic [CODE_W-1:0] curCode;
  logic [CODE_W-1:0] targetCode;
  logic [CODE_W-1:0] stepWide, effStep, gap, move, nextCode;
  logic              rampUp;

  // clamp on load
  always_comb begin
    if (tableWrCode < minCode)      wrClamped = minCode;
    else if (tableWrCode > maxCode) wrClamped = maxCode;
    else                            wrClamped = tableWrCode;
    wrDivFix = (tableWrDiv == 2'b11) ? DIV_BY4 : tableWrDiv;
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    logic [CODE_W-1:0] codeQ;
    logic [DIV_W-1:0]  divQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        codeQ <= CODE_INIT;
        divQ  <= DIV_BY1;
      end else if (tableWrEn && (tableWrIdx == SEL_W'(e))) begin
        codeQ <= wrClamped;
        divQ  <= wrDivFix;
      end
    end
    assign entryCode[e] = codeQ;
    assign entryDiv[e]  = divQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) activeIdx <= '0;
    else if (strb.latchTarget) activeIdx <= strb.newIdx;
  end

  assign targetCode = entryCode[activeIdx];

  // bounded step towards the target
  always_comb begin
    stepWide = CODE_W'(stepSize);
    if (stepWide == '0)          effStep = CODE_W'(1);
    else if (stepWide > STEP_CAP) effStep = STEP_CAP;
    else                          effStep = stepWide;
    rampUp   = curCode < targetCode;
    gap      = rampUp ? (targetCode - curCode) : (curCode - targetCode);
    move     = (gap < effStep) ? gap : effStep;
    nextCode = rampUp ? (curCode + move) : (curCode - move);
  end

  always_ff @(posedge clk) begin
    if (!rstN) curCode <= CODE_INIT;
    else if (strb.rampTick) curCode <= nextCode;
  end

  assign freqCode = curCode;
  assign postDiv  = entryDiv[activeIdx];
  assign settled  = (curCode == targetCode);

  // R5: code only moves on a tick
  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rampTick |=> $stable(curCode));

  // R5: rising ramp never passes its target
  assert_no_overshoot_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rampTick && (curCode <= targetCode)) |=> (curCode <= $past(targetCode)));

  // R5: falling ramp never passes its target
  assert_no_overshoot_dn_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rampTick && (curCode >= targetCode)) |=> (curCode >= $past(targetCode)));

  // R6: one tick never moves further than the cap
  assert_step_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rampTick |=> ((curCode >= $past(curCode) ? curCode - $past(curCode)
                                                   : $past(curCode) - curCode) <= STEP_CAP));

  // R2: a written entry lies inside the window of its write cycle
  assert_write_clamp_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tableWrEn && (minCode <= maxCode)) |=>
      ((entryCode[$past(tableWrIdx)] >= $past(minCode)) &&
       (entryCode[$past(tableWrIdx)] <= $past(maxCode))));

  // R3: the divider output never shows the unused encoding
  assert_div_encoding_R3: assert property (@(posedge clk) disable iff (!rstN)
    postDiv != 2'b11);

  // R8: a settled code stays settled without tick or write
  assert_settled_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (settled && !strb.rampTick && !tableWrEn) |=> settled);
endmodule

// File: rtl/cpu_slew_sel.sv
module cpu_slew_sel
  import cpuslew_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int STEP_W    = 5,
  parameter int STEP_MAX  = 20,
  parameter int RST_CODE  = 8,
  parameter int DEB_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        selIn,
  input  logic              suspendMode,
  input  logic              tickIn,
  input  logic [STEP_W-1:0] stepSize,
  input  logic [CODE_W-1:0] minCode,
  input  logic [CODE_W-1:0] maxCode,
  input  logic              tableWrEn,
  input  logic [2:0]        tableWrIdx,
  input  logic [CODE_W-1:0] tableWrCode,
  input  logic [1:0]        tableWrDiv,
  output logic [CODE_W-1:0] freqCode,
  output logic [1:0]        postDiv,
  output logic              settled,
  output logic              suspendOut
);
  ctlStrobe_t strb;

  cpuslew_ctrl #(.DEB_TICKS(DEB_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .suspendMode(suspendMode),
    .tickIn(tickIn), .strb(strb), .suspendOut(suspendOut)
  );

  cpuslew_datapath #(
    .CODE_W(CODE_W), .STEP_W(STEP_W), .STEP_MAX(STEP_MAX), .RST_CODE(RST_CODE)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .tableWrEn(tableWrEn), .tableWrIdx(tableWrIdx), .tableWrCode(tableWrCode),
    .tableWrDiv(tableWrDiv), .stepSize(stepSize), .minCode(minCode), .maxCode(maxCode),
    .freqCode(freqCode), .postDiv(postDiv), .settled(settled)
  );
endmodule

// File: tb/cpu_slew_sel_test.sv
module cpu_slew_sel_test;
  localparam int DEB = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] selIn = 3'b000;
  logic       suspendMode = 1'b0;
  logic       tickIn = 1'b0;
  logic [4:0] stepSize = 5'd5;
  logic [7:0] minCode = 8'd8;
  logic [7:0] maxCode = 8'd100;
  logic       tableWrEn = 1'b0;
  logic [2:0] tableWrIdx = 3'd0;
  logic [7:0] tableWrCode = 8'd0;
  logic [1:0] tableWrDiv = 2'b00;
  logic [7:0] freqCode;
  logic [1:0] postDiv;
  logic       settled;
  logic       suspendOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mdlCur = 8, mdlTgt = 8, mdlDiv = 0;
  int pendTgt = 0, pendDiv = 0, pendCnt = 0;

  always #10 clk = ~clk;

  cpu_slew_sel uut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .suspendMode(suspendMode), .tickIn(tickIn),
    .stepSize(stepSize), .minCode(minCode), .maxCode(maxCode), .tableWrEn(tableWrEn),
    .tableWrIdx(tableWrIdx), .tableWrCode(tableWrCode), .tableWrDiv(tableWrDiv),
    .freqCode(freqCode), .postDiv(postDiv), .settled(settled), .suspendOut(suspendOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int effStep(input int s);
    if (s == 0) return 1;
    if (s > 20) return 20;
    return s;
  endfunction

  task automatic writeEntry(input int idx, input int code, input int dv);
    @(negedge clk);
    tableWrEn = 1'b1; tableWrIdx = 3'(idx); tableWrCode = 8'(code); tableWrDiv = 2'(dv);
    @(negedge clk);
    tableWrEn = 1'b0;
  endtask

  // drive a select and arm the model's debounce count
  task automatic armSel(input logic [2:0] s, input int tgt, input int dv);
    @(negedge clk);
    selIn = s;
    repeat (3) @(negedge clk);
    pendTgt = tgt; pendDiv = dv; pendCnt = DEB;
  endtask

  // one tick; model steps towards the old target, then latches (R5, R10)
  task automatic doTick(input string req);
    int e;
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
    e = effStep(int'(stepSize));
    if (mdlCur < mdlTgt) mdlCur += (mdlTgt - mdlCur < e) ? mdlTgt - mdlCur : e;
    else if (mdlCur > mdlTgt) mdlCur -= (mdlCur - mdlTgt < e) ? mdlCur - mdlTgt : e;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin mdlTgt = pendTgt; mdlDiv = pendDiv; end
    end
    chk({req, " freqCode"}, int'(freqCode), mdlCur);
    chk("R8 settled", int'(settled), int'(mdlCur == mdlTgt));
    chk("R3 postDiv", int'(postDiv), mdlDiv);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 freqCode", int'(freqCode), 8);
    chk("R1 postDiv", int'(postDiv), 0);
    chk("R1 settled", int'(settled), 1);
    chk("R1 suspendOut", int'(suspendOut), 0);
  endtask

  task automatic testLoad();
    writeEntry(1, 20, 1);
    writeEntry(2, 200, 0);  // R2 above window -> 100
    writeEntry(3, 3, 3);    // R2 below window -> 8, R3 div 11 -> 10
    writeEntry(4, 50, 0);
    chk("R2 no effect on idle output", int'(freqCode), 8);
  endtask

  task automatic testRampUp();
    stepSize = 5'd5;
    armSel(3'b001, 20, 1);
    for (int i = 0; i < 7; i++) doTick("R5 R10 ramp up");
  endtask

  task automatic testClampAndCap();
    stepSize = 5'd25;  // R6 acts as 20
    armSel(3'b010, 100, 0);
    for (int i = 0; i < 8; i++) doTick("R2 R6 ramp to clamped max");
    chk("R2 clamped top reached", int'(freqCode), 100);
  endtask

  task automatic testDebounceRestart();
    armSel(3'b100, 50, 0);
    doTick("R4 debounce partial");
    doTick("R4 debounce partial");
    armSel(3'b011, 8, 2);   // change before latch restarts the count
    doTick("R4 restart 1");
    doTick("R4 restart 2");
    chk("R4 not yet latched", int'(settled), 1);
    doTick("R4 latch on third tick");
    chk("R3 div 11 stored as 10", int'(postDiv), 2);
  endtask

  task automatic testRetarget();
    stepSize = 5'd0;  // R6 acts as 1
    for (int i = 0; i < 3; i++) doTick("R6 zero step");
    chk("R6 zero step moved 3", int'(freqCode), 97);
    stepSize = 5'd25;
    armSel(3'b100, 50, 0);
    for (int i = 0; i < 4; i++) doTick("R7 R10 retarget mid ramp");
    chk("R7 continued from current code", int'(freqCode), 50);
  endtask

  task automatic testSuspend();
    suspendMode = 1'b1;
    armSel(3'b101, 20, 1);  // R9 index 1 in suspend mode
    chk("R9 no suspend with bit high", int'(suspendOut), 0);
    for (int i = 0; i < 5; i++) doTick("R9 four-entry select");
    @(negedge clk); selIn = 3'b001;
    repeat (3) @(negedge clk);
    chk("R9 suspend on low bit", int'(suspendOut), 1);
    for (int i = 0; i < 4; i++) doTick("R9 top bit ignored");
    chk("R9 entry kept", int'(freqCode), 20);
    suspendMode = 1'b0;
    @(negedge clk);
    chk("R9 suspend cleared outside mode", int'(suspendOut), 0);
  endtask

  initial begin
    testReset();
    testLoad();
    testRampUp();
    testClampAndCap();
    testDebounceRestart();
    testRetarget();
    testSuspend();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule